// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block sequences a microcontroller's external memory traffic. Internal agents hand it one request at a time: a code fetch, a data read or a data write. It plays each request out on a multiplexed bus made of two byte-wide ports, up to two extra address pins, an address latch strobe (`ale`) and three active-low strobes: `psen_n` for fetches, `rd_n` for reads and `wr_n` for writes. An external transparent latch captures the multiplexed address byte when `ale` falls. The bus then turns around and carries data.

Configuration inputs are captured once, in the first clock after reset is released. They set the lane mapping, the external address width, and the preset stretch of the strobe and of `ale`. In nonpage mode the data byte shares the port that carries A7:0. In page mode the data byte shares the port that carries A15:8. In page mode a code fetch whose upper address matches the byte held in the external latch skips the whole address phase. A live two-bit control input lets an external wait line extend the active strobe beyond its preset length.

Top module: `ext_bus_ctl`

## Requirements
- R1: While `rst_n` is low, `rd_n`, `wr_n` and `psen_n` are high, `ale` is low, every output enable (`p0_oe`, `p2_oe`, `xa_oe`) is low, and `req_ready` and `done` are low.
- R2: In a nonpage cycle, `ale` is high for 1 + ALE-wait cycles with A7:0 on `p0_out` and A15:8 on `p2_out`. One hold cycle follows. The strobe is then low for 1 + strobe-wait cycles, with A15:8 still driven on `p2_out`.
- R3: In page mode, A7:0 stays on `p0_out` for the whole cycle and the data byte travels on port 2. During `ale`, A15:8 is on `p2_out`.
- R4: On a write (`req_kind` = 2), the data lane drives `req_wdata` from the hold cycle until `wr_n` rises. On a fetch (kind 0) or read (kind 1 or 3), the data lane output enable is low during the strobe. The data lane input is captured at the clock edge where the strobe rises, and it appears on `rdata` in the cycle `done` is high.
- R5: In page mode, a fetch whose address bits above bit 7 equal those held in the external latch issues no `ale`. It runs only a `psen_n` phase of 1 + strobe-wait cycles, with the new A7:0 on `p0_out`.
- R6: Every cycle that pulses `ale` reloads the latched page value, whether it is a fetch, a read or a write. Reads, writes, page misses and all nonpage fetches run the full address phase.
- R7: `cfg_addr_bits` selects the external address width: 0 gives 16 bits, 1 gives 17 bits, and 2 or 3 give 18 bits. Extra pin i is enabled and carries address bit 16+i only when it is within that width. Disabled address bits are treated as zero, including in the page comparison.
- R8: The mode, width and wait settings are sampled only in the first cycle after reset release. Later changes to them have no effect until the next reset.
- R9: `rtw_ctl` bit 0 enables real-time waits for `rd_n` and `psen_n`, and bit 1 enables them for `wr_n`. While the wait is enabled for the active strobe, `ext_wait` high at the end of the preset count keeps the strobe low for another cycle.
- R10: `req_ready` is high only when the block is idle and configured. `done` is a single-cycle pulse in the cycle right after the strobe rises.
- R11: At most one of `rd_n`, `wr_n` and `psen_n` is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_mode | input | 1 | 1 selects page mode (sampled after reset) |
| cfg_addr_bits | input | 2 | External address width code (sampled after reset) |
| cfg_strobe_waits | input | SW_W (2) | Preset strobe wait states (sampled after reset) |
| cfg_ale_waits | input | AW_W (1) | Preset ALE wait states (sampled after reset) |
| rtw_ctl | input | 2 | Real-time wait enables: bit 0 read/fetch, bit 1 write |
| ext_wait | input | 1 | External wait request |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | ADDR_W (18) | Request address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read or fetch data, valid with `done` |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 output enable |
| p0_in | input | 8 | Port 0 pin value |
| p2_out | output | 8 | Port 2 output value |
| p2_oe | output | 1 | Port 2 output enable |
| p2_in | input | 8 | Port 2 pin value |
| xa_out | output | ADDR_W-16 (2) | Extra address pins A16 upward |
| xa_oe | output | ADDR_W-16 (2) | Per-pin enables for the extra address pins |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |
| psen_n | output | 1 | Code fetch strobe |

## Verification
A corrupted sequencer state or wait counter shows up within the same transaction as a wrong count of `ale` or strobe cycles, a missing hold cycle, or a `done` pulse that arrives early or late. A stale or badly masked page register shows up on the next page-mode fetch, as an `ale` pulse that should be absent or a missing `ale` pulse that lets a fetch run against the wrong latched page. A lane-mapping error shows up in the first strobe cycle as the wrong port driven or released. Because the data lane input changes every strobe cycle, capturing it one cycle too early is visible in `rdata`.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  localparam int LANE_W = 8;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_HOLD = 2'd2,
    ST_STRB = 2'd3
  } bus_state_e;

  function automatic logic kind_is_write(input logic [1:0] k);
    return k == KIND_WRITE;
  endfunction

  function automatic logic kind_is_fetch(input logic [1:0] k);
    return k == KIND_FETCH;
  endfunction

endpackage

// File: rtl/ebc_cfg_latch.sv
module ebc_cfg_latch #(
  parameter int SW_W = 2,
  parameter int AW_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            page_i,
  input  logic [1:0]      abits_i,
  input  logic [SW_W-1:0] sw_i,
  input  logic [AW_W-1:0] aw_i,
  output logic            page_o,
  output logic [1:0]      abits_o,
  output logic [SW_W-1:0] sw_o,
  output logic [AW_W-1:0] aw_o,
  output logic            ready_o
);

  logic            taken_q;
  logic            load_en;
  logic            page_q;
  logic [1:0]      abits_q;
  logic [SW_W-1:0] sw_q;
  logic [AW_W-1:0] aw_q;

  assign load_en = !taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      page_q  <= 1'b0;
      abits_q <= '0;
      sw_q    <= '0;
      aw_q    <= '0;
    end else if (load_en) begin
      taken_q <= 1'b1;
      page_q  <= page_i;
      abits_q <= abits_i;
      sw_q    <= sw_i;
      aw_q    <= aw_i;
    end
  end

  assign page_o  = page_q;
  assign abits_o = abits_q;
  assign sw_o    = sw_q;
  assign aw_o    = aw_q;
  assign ready_o = taken_q;

endmodule

// File: rtl/ebc_page_track.sv
module ebc_page_track #(
  parameter int PG_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PG_W-1:0] load_pg_i,
  input  logic [PG_W-1:0] cmp_pg_i,
  output logic            hit_o
);

  logic            vld_q;
  logic [PG_W-1:0] pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pg_q  <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      pg_q  <= load_pg_i;
    end
  end

  assign hit_o = vld_q && (pg_q == cmp_pg_i);

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SW_W   = 2,
  parameter int AW_W   = 1,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ready_i,
  input  logic [SW_W-1:0]   sw_i,
  input  logic [AW_W-1:0]   aw_i,
  input  logic [1:0]        rtw_ctl_i,
  input  logic              ext_wait_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANE_W-1:0] req_wdata_i,
  input  logic              page_hit_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              strb_end_o,
  output bus_state_e        state_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANE_W-1:0] wdata_o
);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] wdata_q;
  logic              done_q;
  logic              accept;
  logic              strb_end;
  logic              rtw_hold;
  logic [CNT_W-1:0]  aw_lim;
  logic [CNT_W-1:0]  sw_lim;

  assign aw_lim      = CNT_W'(aw_i);
  assign sw_lim      = CNT_W'(sw_i);
  assign req_ready_o = (state_q == ST_IDLE) && cfg_ready_i;
  assign accept      = req_ready_o && req_valid_i;
  assign rtw_hold    = ext_wait_i &&
                       (kind_is_write(kind_q) ? rtw_ctl_i[1] : rtw_ctl_i[0]);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    strb_end = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = page_hit_i ? ST_STRB : ST_ADDR;
          cnt_d   = '0;
        end
      end
      ST_ADDR: begin
        if (cnt_q >= aw_lim) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_HOLD: begin
        state_d = ST_STRB;
        cnt_d   = '0;
      end
      ST_STRB: begin
        if (cnt_q < sw_lim) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else if (!rtw_hold) begin
          state_d  = ST_IDLE;
          cnt_d    = '0;
          strb_end = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= strb_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= req_kind_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  assign done_o     = done_q;
  assign strb_end_o = strb_end;
  assign state_o    = state_q;
  assign kind_o     = kind_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;

endmodule

// File: rtl/ebc_lane_drv.sv
module ebc_lane_drv
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int XA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              page_i,
  input  logic [1:0]        abits_i,
  input  logic              strb_end_i,
  input  logic [LANE_W-1:0] p0_in,
  input  logic [LANE_W-1:0] p2_in,
  output logic [LANE_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [LANE_W-1:0] p2_out,
  output logic              p2_oe,
  output logic [XA_W-1:0]   xa_out,
  output logic [XA_W-1:0]   xa_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n,
  output logic [LANE_W-1:0] rdata
);

  logic              active;
  logic              in_addr;
  logic              in_strb;
  logic              wr_drive;
  logic              mux_oe;
  logic [LANE_W-1:0] lo_byte;
  logic [LANE_W-1:0] hi_byte;
  logic [LANE_W-1:0] rdata_q;
  logic [LANE_W-1:0] lane_in;

  assign active   = state_i != ST_IDLE;
  assign in_addr  = state_i == ST_ADDR;
  assign in_strb  = state_i == ST_STRB;
  assign wr_drive = kind_is_write(kind_i) &&
                    ((state_i == ST_HOLD) || in_strb);
  assign mux_oe   = in_addr || wr_drive;
  assign lo_byte  = addr_i[LANE_W-1:0];
  assign hi_byte  = addr_i[2*LANE_W-1:LANE_W];

  always_comb begin
    if (page_i) begin
      p0_out = lo_byte;
      p0_oe  = active;
      p2_out = wr_drive ? wdata_i : hi_byte;
      p2_oe  = active && mux_oe;
    end else begin
      p0_out = wr_drive ? wdata_i : lo_byte;
      p0_oe  = active && mux_oe;
      p2_out = hi_byte;
      p2_oe  = active;
    end
  end

  for (genvar gi = 0; gi < XA_W; gi++) begin : g_xa
    logic pin_used;
    assign pin_used   = {30'd0, abits_i} >= (gi + 1);
    assign xa_out[gi] = addr_i[16+gi];
    assign xa_oe[gi]  = active && pin_used;
  end

  assign ale    = in_addr;
  assign psen_n = !(in_strb && kind_is_fetch(kind_i));
  assign wr_n   = !(in_strb && kind_is_write(kind_i));
  assign rd_n   = !(in_strb && !kind_is_fetch(kind_i) && !kind_is_write(kind_i));

  assign lane_in = page_i ? p2_in : p0_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (strb_end_i) begin
      rdata_q <= lane_in;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SW_W   = 2,
  parameter int AW_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page_mode,
  input  logic [1:0]        cfg_addr_bits,
  input  logic [SW_W-1:0]   cfg_strobe_waits,
  input  logic [AW_W-1:0]   cfg_ale_waits,
  input  logic [1:0]        rtw_ctl,
  input  logic              ext_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              done,
  output logic [7:0]        rdata,
  output logic [7:0]        p0_out,
  output logic              p0_oe,
  input  logic [7:0]        p0_in,
  output logic [7:0]        p2_out,
  output logic              p2_oe,
  input  logic [7:0]        p2_in,
  output logic [ADDR_W-17:0] xa_out,
  output logic [ADDR_W-17:0] xa_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n
);

  localparam int XA_W  = ADDR_W - 16;
  localparam int PG_W  = ADDR_W - LANE_W;
  localparam int CNT_W = (SW_W > AW_W) ? SW_W : AW_W;

  logic              cfg_page;
  logic [1:0]        cfg_abits;
  logic [SW_W-1:0]   cfg_sw;
  logic [AW_W-1:0]   cfg_aw;
  logic              cfg_ready;
  logic [ADDR_W-1:0] addr_mask;
  logic [ADDR_W-1:0] eff_addr;
  logic              trk_hit;
  logic              page_hit;
  logic              strb_end;
  bus_state_e        state;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  ebc_cfg_latch #(.SW_W(SW_W), .AW_W(AW_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .page_i  (cfg_page_mode),
    .abits_i (cfg_addr_bits),
    .sw_i    (cfg_strobe_waits),
    .aw_i    (cfg_ale_waits),
    .page_o  (cfg_page),
    .abits_o (cfg_abits),
    .sw_o    (cfg_sw),
    .aw_o    (cfg_aw),
    .ready_o (cfg_ready)
  );

  always_comb begin
    addr_mask = '1;
    for (int i = 0; i < XA_W; i++) begin
      addr_mask[16+i] = {30'd0, cfg_abits} >= (i + 1);
    end
  end

  assign eff_addr = req_addr & addr_mask;

  ebc_page_track #(.PG_W(PG_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (state == ST_ADDR),
    .load_pg_i (addr_q[ADDR_W-1:LANE_W]),
    .cmp_pg_i  (eff_addr[ADDR_W-1:LANE_W]),
    .hit_o     (trk_hit)
  );

  assign page_hit = cfg_page && kind_is_fetch(req_kind) && trk_hit;

  ebc_seq #(
    .ADDR_W (ADDR_W),
    .SW_W   (SW_W),
    .AW_W   (AW_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ready_i (cfg_ready),
    .sw_i        (cfg_sw),
    .aw_i        (cfg_aw),
    .rtw_ctl_i   (rtw_ctl),
    .ext_wait_i  (ext_wait),
    .req_valid_i (req_valid),
    .req_kind_i  (req_kind),
    .req_addr_i  (eff_addr),
    .req_wdata_i (req_wdata),
    .page_hit_i  (page_hit),
    .req_ready_o (req_ready),
    .done_o      (done),
    .strb_end_o  (strb_end),
    .state_o     (state),
    .kind_o      (kind_q),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q)
  );

  ebc_lane_drv #(.ADDR_W(ADDR_W), .XA_W(XA_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .kind_i     (kind_q),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .page_i     (cfg_page),
    .abits_i    (cfg_abits),
    .strb_end_i (strb_end),
    .p0_in      (p0_in),
    .p2_in      (p2_in),
    .p0_out     (p0_out),
    .p0_oe      (p0_oe),
    .p2_out     (p2_out),
    .p2_oe      (p2_oe),
    .xa_out     (xa_out),
    .xa_oe      (xa_oe),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .psen_n     (psen_n),
    .rdata      (rdata)
  );

endmodule

// File: rtl/ebc_chk.sv
module ebc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rtw_ctl,
  input logic       ext_wait,
  input logic       req_ready,
  input logic       done,
  input logic       p0_oe,
  input logic       p2_oe,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       psen_n
);

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !psen_n}) <= 1);

  // R2
  ale_addr_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (p0_oe && p2_oe && rd_n && wr_n && psen_n));

  // R4
  write_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (p0_oe && p2_oe));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !(p0_oe && p2_oe));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !rd_n || !wr_n || !psen_n) |-> !req_ready);

  // R10
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!rd_n || !wr_n || !psen_n) && rd_n && wr_n && psen_n));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  rtw_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_n && rtw_ctl[0] && ext_wait) |-> !rd_n);

  // R9
  rtw_fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!psen_n && rtw_ctl[0] && ext_wait) |-> !psen_n);

  // R9
  rtw_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_n && rtw_ctl[1] && ext_wait) |-> !wr_n);

endmodule

bind ext_bus_ctl ebc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rtw_ctl   (rtw_ctl),
  .ext_wait  (ext_wait),
  .req_ready (req_ready),
  .done      (done),
  .p0_oe     (p0_oe),
  .p2_oe     (p2_oe),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .psen_n    (psen_n)
);

// File: tb/ext_bus_ctl_tb.sv
`timescale 1ns/100ps
module ext_bus_ctl_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_page_mode;
  logic [1:0]  cfg_addr_bits;
  logic [1:0]  cfg_strobe_waits;
  logic [0:0]  cfg_ale_waits;
  logic [1:0]  rtw_ctl;
  logic        ext_wait;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [17:0] req_addr;
  logic [7:0]  req_wdata;
  logic        done;
  logic [7:0]  rdata;
  logic [7:0]  p0_out, p2_out, p0_in, p2_in;
  logic        p0_oe, p2_oe;
  logic [1:0]  xa_out, xa_oe;
  logic        ale, rd_n, wr_n, psen_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cur_page;
  logic [1:0] cur_ab;

  int m_ale, m_strb, m_total, m_addr_err, m_lane_err, m_other, m_busy;
  logic [7:0] m_rdata, m_exp_base;
  bit m_timeout;

  ext_bus_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_page_mode(cfg_page_mode),
    .cfg_addr_bits(cfg_addr_bits), .cfg_strobe_waits(cfg_strobe_waits),
    .cfg_ale_waits(cfg_ale_waits), .rtw_ctl(rtw_ctl), .ext_wait(ext_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
    .p2_oe(p2_oe), .p2_in(p2_in), .xa_out(xa_out), .xa_oe(xa_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        page;
    logic [1:0]  kind;
    logic [17:0] addr;
    logic [7:0]  wd;
    logic [1:0]  sw;
    logic        aw;
    logic [1:0]  ab;
    logic [2:0]  exp_ale;
    logic [2:0]  exp_strb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd1, 18'h012A5, 8'h00, 2'd0, 1'b0, 2'd0, 3'd1, 3'd1},
    '{1'b0, 2'd2, 18'h03C5A, 8'h96, 2'd1, 1'b0, 2'd0, 3'd1, 3'd2},
    '{1'b0, 2'd0, 18'h17F01, 8'h00, 2'd3, 1'b1, 2'd1, 3'd2, 3'd4},
    '{1'b1, 2'd1, 18'h04455, 8'h00, 2'd0, 1'b1, 2'd0, 3'd2, 3'd1},
    '{1'b1, 2'd2, 18'h28001, 8'h3C, 2'd2, 1'b0, 2'd2, 3'd1, 3'd3},
    '{1'b1, 2'd0, 18'h3FFFE, 8'h00, 2'd1, 1'b0, 2'd3, 3'd1, 3'd2},
    '{1'b0, 2'd2, 18'h30000, 8'hFF, 2'd0, 1'b0, 2'd2, 3'd1, 3'd1},
    '{1'b0, 2'd3, 18'h0FFFF, 8'h00, 2'd2, 1'b1, 2'd0, 3'd2, 3'd3}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [17:0] amask(input logic [1:0] ab);
    logic [17:0] m;
    m = 18'h0FFFF;
    m[16] = ab >= 2'd1;
    m[17] = ab >= 2'd2;
    return m;
  endfunction

  task automatic do_reset(input bit pg, input logic [1:0] ab,
                          input logic [1:0] sw, input logic aw);
    cfg_page_mode = pg; cfg_addr_bits = ab;
    cfg_strobe_waits = sw; cfg_ale_waits = aw;
    rtw_ctl = 2'b00; ext_wait = 1'b0; req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_n && wr_n && psen_n && !ale, "R1 strobes", {rd_n, wr_n, psen_n, ale}, 4'b1110);
    chk(!p0_oe && !p2_oe && xa_oe == 2'b00 && !req_ready && !done, "R1 enables",
        {p0_oe, p2_oe, xa_oe, req_ready, done}, 0);
    rst_n = 1'b1;
    cur_page = pg; cur_ab = ab;
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [1:0] kind, input logic [17:0] addr,
                         input logic [7:0] wd, input int hold);
    logic [17:0] ea;
    logic [7:0] b0, b2;
    bit es, os;
    int guard;
    ea = addr & amask(cur_ab);
    b0 = ~ea[7:0];
    b2 = ea[7:0] ^ 8'h5A;
    m_exp_base = cur_page ? b2 : b0;
    m_ale = 0; m_strb = 0; m_total = 0; m_addr_err = 0;
    m_lane_err = 0; m_other = 0; m_busy = 0; m_timeout = 1'b0;
    p0_in = b0; p2_in = b2; ext_wait = hold > 0;
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_timeout = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (done) begin
        m_rdata = rdata;
        m_timeout = 1'b0;
        break;
      end
      m_total++;
      if (req_ready) m_busy++;
      case (kind)
        2'd0: begin es = !psen_n; os = !rd_n || !wr_n; end
        2'd2: begin es = !wr_n; os = !rd_n || !psen_n; end
        default: begin es = !rd_n; os = !wr_n || !psen_n; end
      endcase
      if (os || (ale && es)) m_other++;
      if (ale) begin
        m_ale++;
        if (!(p0_oe && p2_oe && p0_out == ea[7:0] && p2_out == ea[15:8])) m_addr_err++;
        for (int k = 0; k < 2; k++) begin
          if (xa_oe[k] != (cur_ab >= 2'(k + 1))) m_addr_err++;
          else if (xa_oe[k] && xa_out[k] != ea[16+k]) m_addr_err++;
        end
      end
      if (es) begin
        m_strb++;
        if (cur_page) begin
          if (!(p0_oe && p0_out == ea[7:0])) m_lane_err++;
          if (kind == 2'd2) begin
            if (!(p2_oe && p2_out == wd)) m_lane_err++;
          end else if (p2_oe) m_lane_err++;
        end else begin
          if (!(p2_oe && p2_out == ea[15:8])) m_lane_err++;
          if (kind == 2'd2) begin
            if (!(p0_oe && p0_out == wd)) m_lane_err++;
          end else if (p0_oe) m_lane_err++;
        end
        p0_in = b0 + 8'(m_strb);
        p2_in = b2 + 8'(m_strb);
        ext_wait = m_strb < hold;
      end
      @(negedge clk);
    end
    ext_wait = 1'b0;
  endtask

  task automatic check_txn(input string rq, input int e_ale, input int e_strb,
                           input logic [1:0] kind);
    int e_tot;
    e_tot = e_ale + ((e_ale > 0) ? 1 : 0) + e_strb;
    chk(!m_timeout, "R10 done seen", m_timeout, 0);
    chk(m_ale == e_ale, {rq, " ale cycles"}, m_ale, e_ale);
    chk(m_strb == e_strb, {rq, " strobe cycles"}, m_strb, e_strb);
    chk(m_total == e_tot, "R10 done timing", m_total, e_tot);
    chk(m_addr_err == 0, "R2 R7 address on ports", m_addr_err, 0);
    chk(m_lane_err == 0, "R3 R4 lane use", m_lane_err, 0);
    chk(m_other == 0, "R11 strobe exclusivity", m_other, 0);
    chk(m_busy == 0, "R10 ready while busy", m_busy, 0);
    if (kind != 2'd2)
      chk(m_rdata == m_exp_base + 8'(e_strb), "R4 read capture", m_rdata,
          m_exp_base + 8'(e_strb));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
    req_wdata = '0; p0_in = '0; p2_in = '0; ext_wait = 1'b0; rtw_ctl = 2'b00;
    cfg_page_mode = 1'b0; cfg_addr_bits = 2'd0; cfg_strobe_waits = 2'd0;
    cfg_ale_waits = 1'b0;

    // table walk: R2, R3, R4, R7
    for (int v = 0; v < 8; v++) begin
      do_reset(VECS[v].page, VECS[v].ab, VECS[v].sw, VECS[v].aw);
      run_txn(VECS[v].kind, VECS[v].addr, VECS[v].wd, 0);
      check_txn(VECS[v].page ? "R3" : "R2", int'(VECS[v].exp_ale),
                int'(VECS[v].exp_strb), VECS[v].kind);
    end

    // R5 R6 page-mode latch tracking
    do_reset(1'b1, 2'd0, 2'd0, 1'b0);
    run_txn(2'd0, 18'h01234, 8'h00, 0); check_txn("R6 first fetch", 1, 1, 2'd0);
    run_txn(2'd0, 18'h01256, 8'h00, 0); check_txn("R5 page hit", 0, 1, 2'd0);
    run_txn(2'd0, 18'h01356, 8'h00, 0); check_txn("R6 page miss", 1, 1, 2'd0);
    run_txn(2'd1, 18'h013AA, 8'h00, 0); check_txn("R6 read full", 1, 1, 2'd1);
    run_txn(2'd0, 18'h01300, 8'h00, 0); check_txn("R6 hit after read", 0, 1, 2'd0);
    run_txn(2'd0, 18'h21300, 8'h00, 0); check_txn("R7 masked hit", 0, 1, 2'd0);
    run_txn(2'd2, 18'h01300, 8'h77, 0); check_txn("R6 write full", 1, 1, 2'd2);

    // R6 nonpage never skips
    do_reset(1'b0, 2'd2, 2'd0, 1'b0);
    run_txn(2'd0, 18'h01234, 8'h00, 0); check_txn("R6 nonpage fetch", 1, 1, 2'd0);
    run_txn(2'd0, 18'h01234, 8'h00, 0); check_txn("R6 nonpage repeat", 1, 1, 2'd0);

    // R8 config changes after sampling are ignored
    do_reset(1'b0, 2'd0, 2'd0, 1'b0);
    cfg_page_mode = 1'b1; cfg_strobe_waits = 2'd3; cfg_ale_waits = 1'b1;
    cfg_addr_bits = 2'd3;
    run_txn(2'd1, 18'h0ABCD, 8'h00, 0); check_txn("R8 late config", 1, 1, 2'd1);

    // R9 real-time waits
    do_reset(1'b0, 2'd0, 2'd0, 1'b0);
    rtw_ctl = 2'b01;
    run_txn(2'd1, 18'h00F0F, 8'h00, 3); check_txn("R9 read wait", 1, 3, 2'd1);
    run_txn(2'd2, 18'h00F0F, 8'h5A, 3); check_txn("R9 write not enabled", 1, 1, 2'd2);
    rtw_ctl = 2'b10;
    run_txn(2'd2, 18'h00E0E, 8'hA5, 4); check_txn("R9 write wait", 1, 4, 2'd2);
    do_reset(1'b0, 2'd0, 2'd2, 1'b0);
    rtw_ctl = 2'b01;
    run_txn(2'd0, 18'h00C0C, 8'h00, 2); check_txn("R9 preset dominates", 1, 3, 2'd0);
    rtw_ctl = 2'b00;
    run_txn(2'd1, 18'h00C0C, 8'h00, 5); check_txn("R9 disabled", 1, 3, 2'd1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule